// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 18-bit words whose write side and read side each run on their own free-running clock. The two clocks may be unrelated or may be the same net. Each side moves one word per clock edge while its enable is held high. Words leave in the order they entered. Writing and reading may go on at the same time.

The block reports five status flags. Full, Half Full and Almost Full are registered in the write clock domain. Empty and Almost Empty are registered in the read clock domain. The two almost thresholds are offsets held in registers. They are loaded through the write port while a configuration strobe is high, and after reset each one is one eighth of the depth.

A retransmit strobe moves the read position back to where it stood at reset, so that words already read can be read again. The read data bus has an output enable that floats it.

Top module: `xclk_flag_fifo`

## Requirements
- R1: Words are read out in the order they were written, and each read word equals the 18-bit word written at that position.
- R2: Reads and writes may take place in the same period on independent clocks. A word written on the write side is eventually readable on the read side.
- R3: Full is high exactly when DEPTH words are stored. A write request while Full is high stores nothing and moves no pointer, so the DEPTH stored words are read back unchanged.
- R4: Empty is high exactly when no word is stored. A read request while Empty is high is ignored, and rd_data keeps its previous value.
- R5: half_full is high when the stored count is strictly greater than DEPTH/2.
- R6: almost_full is high when the count is at least DEPTH minus the full offset. almost_empty is high when the count is at most the empty offset.
- R7: While cfg_load is high, each write-enabled clock edge stores wr_data[AW-1:0] into an offset register instead of the buffer. The edges alternate between the empty offset (first) and the full offset (second). Both offsets reset to DEPTH/8, and a load stores no data word.
- R8: If retx is high on a read clock edge while rd_en is low, the read position returns to its reset position, and the words written since reset are read again in order. If retx is high while rd_en is high, retx is ignored.
- R9: When oe is low, rd_data does not drive the stored word (high impedance). oe has no effect on reads or on the value presented once oe rises.
- R10: While reset is held and just after it, empty and almost_empty are high, and full, half_full and almost_full are low.
- R11: rd_data changes to the next word at the read clock edge on which rd_en is high and Empty is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| cfg_load | input | 1 | Route write-enabled words to the offset registers |
| wr_data | input | 18 | Write data, or offset value during a load |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| half_full | output | 1 | Count above DEPTH/2 (write domain) |
| almost_full | output | 1 | Count at or above DEPTH minus full offset (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit strobe (read domain) |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | 18 | Read data, floated when oe is low |
| empty | output | 1 | No word stored (read domain) |
| almost_empty | output | 1 | Count at or below empty offset (read domain) |

## Verification
On every clock, the assertions check the following. A pointer never moves on a request made against Full or Empty. Each gray pointer changes by at most one bit per step, except right after a retransmit. Full implies Half Full and Almost Full, and Empty implies Almost Empty. A load cycle leaves the write pointer untouched, and a retransmit with words present clears Empty. Only the bench scenarios can show the rest: data order across unrelated clocks, the exact flag thresholds for loaded offsets, the replay after a retransmit, and the floated bus.

// File: rtl/xff_pkg.sv
package xff_pkg;

   // Which offset register the next configuration write targets.
   typedef enum logic {
      OFF_EMPTY = 1'b0,
      OFF_FULL  = 1'b1
   } off_sel_e;

   localparam int PTR_MAX = 32;

   function automatic logic [PTR_MAX-1:0] to_gray(input logic [PTR_MAX-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PTR_MAX-1:0] from_gray(input logic [PTR_MAX-1:0] g);
      logic [PTR_MAX-1:0] b;
      b[PTR_MAX-1] = g[PTR_MAX-1];
      for (int i = PTR_MAX - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xff_gray_sync.sv
module xff_gray_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xff_gray_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xff_ram.sv
module xff_ram #(
   parameter int DW = 18,
   parameter int AW = 6
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] q
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Registered read port: q only moves on an accepted read.
   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= mem[raddr];
   end

endmodule

// File: rtl/xff_wr_ctl.sv
module xff_wr_ctl
   import xff_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 18,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          cfg_load,
   input  logic [DW-1:0] wr_data,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wgray,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          full,
   output logic          half,
   output logic          afull,
   output logic [AW-1:0] ae_off
);

   localparam logic [AW-1:0] OFF_RST   = AW'(DEPTH / 8);
   localparam logic [PW-1:0] CNT_DEPTH = PW'(DEPTH);
   localparam logic [PW-1:0] CNT_HALF  = PW'(DEPTH / 2);

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_n;
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] cnt_n;
   logic [AW-1:0] af_off;
   off_sel_e      sel;
   logic          do_wr;
   logic          do_cfg;

   assign do_cfg = wr_en && cfg_load;
   assign do_wr  = wr_en && !cfg_load && !full;
   assign wbin_n = wbin + PW'(do_wr);
   assign rbin_s = PW'(from_gray(PTR_MAX'(rgray_s)));
   assign cnt_n  = wbin_n - rbin_s;

   assign we    = do_wr;
   assign waddr = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         full  <= 1'b0;
         half  <= 1'b0;
         afull <= 1'b0;
      end else begin
         wbin  <= wbin_n;
         wgray <= PW'(to_gray(PTR_MAX'(wbin_n)));
         full  <= (cnt_n == CNT_DEPTH);
         half  <= (cnt_n > CNT_HALF);
         afull <= (cnt_n >= (CNT_DEPTH - {1'b0, af_off}));
      end
   end

   // Offset registers: alternate empty/full on each load write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_off <= OFF_RST;
         af_off <= OFF_RST;
         sel    <= OFF_EMPTY;
      end else if (do_cfg) begin
         if (sel == OFF_EMPTY) begin
            ae_off <= wr_data[AW-1:0];
            sel    <= OFF_FULL;
         end else begin
            af_off <= wr_data[AW-1:0];
            sel    <= OFF_EMPTY;
         end
      end
   end

   p_no_overflow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en) |=> $stable(wbin));

   p_cfg_no_store_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cfg_load) |=> $stable(wbin));

   p_wgray_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));

   p_full_flags_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (half && afull));

endmodule

// File: rtl/xff_rd_ctl.sv
module xff_rd_ctl
   import xff_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          retx,
   input  logic [PW-1:0] wgray_s,
   input  logic [AW-1:0] ae_off,
   output logic [PW-1:0] rgray,
   output logic          re,
   output logic [AW-1:0] raddr,
   output logic          empty,
   output logic          aempty
);

   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_n;
   logic [PW-1:0] wbin_s;
   logic [PW-1:0] cnt_n;
   logic          do_rd;
   logic          do_rt;

   assign do_rd  = rd_en && !empty;
   assign do_rt  = retx && !rd_en;
   assign rbin_n = do_rt ? '0 : (rbin + PW'(do_rd));
   assign wbin_s = PW'(from_gray(PTR_MAX'(wgray_s)));
   assign cnt_n  = wbin_s - rbin_n;

   assign re    = do_rd;
   assign raddr = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         empty  <= 1'b1;
         aempty <= 1'b1;
      end else begin
         rbin   <= rbin_n;
         rgray  <= PW'(to_gray(PTR_MAX'(rbin_n)));
         empty  <= (cnt_n == '0);
         aempty <= (cnt_n <= {1'b0, ae_off});
      end
   end

   p_no_underflow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en) |=> $stable(rbin));

   p_empty_in_aempty_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> aempty);

   p_rgray_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(retx) |-> $onehot0(rgray ^ $past(rgray)));

   p_retx_refill_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (retx && !rd_en && (wbin_s != '0)) |=> !empty);

endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
   parameter int DEPTH       = 64,
   parameter int DW          = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic          wr_en,
   input  logic          cfg_load,
   input  logic [DW-1:0] wr_data,
   output logic          full,
   output logic          half_full,
   output logic          almost_full,
   input  logic          rd_clk,
   input  logic          rd_en,
   input  logic          retx,
   input  logic          oe,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic          almost_empty
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("xclk_flag_fifo: DEPTH must be a power of two, at least 8");
   end
   if (DW < AW) begin : g_bad_width
      $error("xclk_flag_fifo: DW must hold an offset value");
   end

   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0] waddr, raddr, ae_off;
   logic          we, re;
   logic [DW-1:0] q;

   xff_wr_ctl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_load(cfg_load),
      .wr_data(wr_data), .rgray_s(rgray_s), .wgray(wgray), .we(we),
      .waddr(waddr), .full(full), .half(half_full), .afull(almost_full),
      .ae_off(ae_off)
   );

   xff_rd_ctl #(.DEPTH(DEPTH)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .retx(retx),
      .wgray_s(wgray_s), .ae_off(ae_off), .rgray(rgray), .re(re),
      .raddr(raddr), .empty(empty), .aempty(almost_empty)
   );

   xff_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   xff_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   xff_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .rclk(rd_clk), .rst_n(rst_n), .re(re), .raddr(raddr), .q(q)
   );

   assign rd_data = oe ? q : {DW{1'bz}};

endmodule

// File: tb/sim_xclk_flag_fifo.sv
`timescale 1ns/1ps
module sim_xclk_flag_fifo;

   localparam int D  = 64;
   localparam int DW = 18;

   logic rst_n = 1'b0;
   logic wclk = 1'b0, rclk = 1'b0;
   logic wr_en = 1'b0, cfg_load = 1'b0, rd_en = 1'b0, retx = 1'b0, oe = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic full, half_full, almost_full, empty, almost_empty;

   int checks = 0, fails = 0;
   logic [DW-1:0] mdl [D];
   int wp = 0, rp = 0;
   int ae = D / 8, af = D / 8;

   always #4 wclk = ~wclk;   // 125 MHz write clock
   always #6 rclk = ~rclk;   // unrelated read clock

   xclk_flag_fifo #(.DEPTH(D), .DW(DW)) u0 (
      .rst_n(rst_n), .wr_clk(wclk), .wr_en(wr_en), .cfg_load(cfg_load),
      .wr_data(wr_data), .full(full), .half_full(half_full),
      .almost_full(almost_full), .rd_clk(rclk), .rd_en(rd_en), .retx(retx),
      .oe(oe), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit ef(int c);  return c == 0;       endfunction
   function automatic bit aef(int c); return c <= ae;      endfunction
   function automatic bit ff(int c);  return c == D;       endfunction
   function automatic bit hf(int c);  return c > D / 2;    endfunction
   function automatic bit aff(int c); return c >= D - af;  endfunction

   task automatic settle();
      repeat (8) @(negedge rclk);
   endtask

   task automatic check_flags(input string req);
      int c;
      settle();
      c = wp - rp;
      chk(empty == ef(c), req, "empty", empty, ef(c));
      chk(almost_empty == aef(c), req, "almost_empty R6", almost_empty, aef(c));
      chk(full == ff(c), req, "full R3", full, ff(c));
      chk(half_full == hf(c), req, "half_full R5", half_full, hf(c));
      chk(almost_full == aff(c), req, "almost_full R6", almost_full, aff(c));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0; rd_en = 1'b0; retx = 1'b0; cfg_load = 1'b0;
      repeat (3) @(negedge rclk);
      chk(empty && almost_empty && !full && !half_full && !almost_full,
          "R10", "flags in reset",
          {empty, almost_empty, full, half_full, almost_full}, 5'b11000);
      @(negedge wclk);
      rst_n = 1'b1;
      wp = 0; rp = 0; ae = D / 8; af = D / 8;
   endtask

   task automatic write_n(input int n);
      if (n <= 0) return;
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wr_en = 1'b1;
         wr_data = DW'($urandom);
         mdl[wp % D] = wr_data;
         wp++;
      end
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic read_n(input int n);
      if (n <= 0) return;
      @(negedge rclk);
      rd_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge rclk);
         if (i == n - 1) rd_en = 1'b0;
         chk(rd_data == mdl[rp % D], "R1/R11", "read word", rd_data, mdl[rp % D]);
         rp++;
      end
   endtask

   task automatic load_offsets(input int new_ae, input int new_af);
      @(negedge wclk);
      cfg_load = 1'b1; wr_en = 1'b1; wr_data = DW'(new_ae);
      @(negedge wclk);
      wr_data = DW'(new_af);
      @(negedge wclk);
      cfg_load = 1'b0; wr_en = 1'b0;
      ae = new_ae; af = new_af;
   endtask

   initial begin : watchdog
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] held;
      int sd;
      sd = $urandom(32'd4711);

      // Reset state and default offsets
      do_reset();
      check_flags("R10");
      write_n(8);
      check_flags("R7 default");
      write_n(1);
      check_flags("R7 default");

      // Load offsets: ae=3, af=5; nothing enters the buffer
      load_offsets(3, 5);
      check_flags("R7 load");
      read_n(5);
      check_flags("R6");
      read_n(1);
      check_flags("R6");
      write_n(D - 6 - 3);
      check_flags("R6");
      write_n(1);
      check_flags("R6");
      write_n(D / 2 - (wp - rp) + 1);
      check_flags("R5");

      // Fill, then writes against Full are dropped
      do_reset();
      write_n(D);
      check_flags("R3");
      for (int i = 0; i < 3; i++) begin
         @(negedge wclk);
         wr_en = 1'b1;
         wr_data = DW'(i + 18'h15555);
      end
      @(negedge wclk);
      wr_en = 1'b0;
      check_flags("R3");
      read_n(D);
      check_flags("R3");
      // Read against Empty: data holds
      held = rd_data;
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      chk(rd_data == held, "R4", "rd_data after read on empty", rd_data, held);
      check_flags("R4");

      // Retransmit replays from reset position
      do_reset();
      write_n(10);
      settle();
      read_n(4);
      settle();
      @(negedge rclk); retx = 1'b1;
      @(negedge rclk); retx = 1'b0;
      rp = 0;
      check_flags("R8");
      read_n(10);
      check_flags("R8");
      write_n(3);
      settle();
      // Retransmit while reading is ignored
      @(negedge rclk); rd_en = 1'b1; retx = 1'b1;
      @(negedge rclk); rd_en = 1'b0; retx = 1'b0;
      chk(rd_data == mdl[rp % D], "R8", "retx with rd_en ignored", rd_data, mdl[rp % D]);
      rp++;
      read_n(2);
      check_flags("R8");

      // Output enable floats the bus but does not disturb the read
      do_reset();
      @(negedge wclk); wr_en = 1'b1; wr_data = 18'h2A5A5; mdl[0] = wr_data; wp = 1;
      @(negedge wclk); wr_en = 1'b0;
      settle();
      oe = 1'b0;
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      chk(rd_data !== 18'h2A5A5, "R9", "bus while oe low", rd_data, 18'h2A5A5);
      rp = 1;
      oe = 1'b1;
      #1;
      chk(rd_data == 18'h2A5A5, "R9", "bus after oe high", rd_data, 18'h2A5A5);
      check_flags("R9");

      // Constrained random traffic with concurrent ports
      for (int it = 0; it < 150; it++) begin
         int c, op, nw, nr;
         c  = wp - rp;
         op = int'($urandom % 4);
         nw = (D - c == 0) ? 0 : 1 + int'($urandom % ((D - c) < 12 ? (D - c) : 12));
         nr = (c == 0) ? 0 : 1 + int'($urandom % (c < 12 ? c : 12));
         case (op)
            0: write_n(nw);
            1: read_n(nr);
            2: fork
                  write_n(nw);
                  read_n(nr);
               join
            default: load_offsets(int'($urandom % D), int'($urandom % D));
         endcase
         check_flags("R2");
      end
      read_n(wp - rp);
      check_flags("R2");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule